// File: doc/BRIEF.md
# Sliced Bus-Mapped Block Memory

This block is a memory core of parameterised word width that sits on a 16-bit daisy-chained register bus. Internally every word is split into 16-bit slices, with as many slices as a word of `WIDTH` bits needs. Each slice is a bank of `DEPTH` entries. On the bus side the banks are laid out one after another, starting at `BASE_ADDR`. Slice k of word a therefore answers at bus address `BASE_ADDR + k*DEPTH + a`. The unused upper bits of the highest slice are not stored.

A bus transaction enters on the `bi_*` inputs and leaves one clock later on the `bo_*` outputs, so several cores can be chained. The core serves reads and writes that fall inside its own address window. All other traffic passes through untouched. A user-side port on the same clock reads and writes the full word at one address per cycle.

The output stage is a four-state machine whose state names the kind of transaction now on the output. `ST_IDLE` means no transaction. `ST_PASS` means forwarded out-of-range traffic. `ST_READ` means an in-range read. `ST_WRITE` means an in-range write. Every cycle the next state is chosen from the incoming transaction:
- not valid → `ST_IDLE`
- valid and out of range → `ST_PASS`
- valid, in range, `bi_rw` low → `ST_READ`
- valid, in range, `bi_rw` high → `ST_WRITE`

Any state can move to any state.

Top module: `sliced_bus_mem`

## Requirements
- R1: A valid transaction at bus address `BASE_ADDR + k*DEPTH + a` (k below ceil(WIDTH/16), a below DEPTH) acts on word a, bits 16k to 16k+15, for both reads and writes.
- R2: For an in-range read (`bi_rw` = 0), `bo_data` one cycle later holds the addressed slice. `bo_addr` and `bo_rw` hold the incoming values.
- R3: An in-range write (`bi_rw` = 1) stores `bi_data` into the addressed slice. One cycle later `bo_data` repeats `bi_data` unchanged.
- R4: In the top slice, bit positions at or above WIDTH read back as 0 on the bus, and writes to them are discarded.
- R5: A valid transaction outside `[BASE_ADDR, BASE_ADDR + slices*DEPTH)` appears on `bo_*` one cycle later with address, data and rw unchanged, and leaves the memory contents unchanged.
- R6: Every transaction has exactly one cycle of latency. `bo_valid` equals `bi_valid` of the previous cycle.
- R7: With `usr_we` high, the full `usr_wdata` word is stored at `usr_addr` on the clock edge. `usr_rdata` shows, one cycle later, the word stored at `usr_addr` before that edge.
- R8: If a bus write and a user write target the same word in the same cycle, the word takes the user value and the bus write is dropped.
- R9: While `rst` is high, `bo_valid`, `bo_addr`, `bo_data` and `bo_rw` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by bus and user side |
| rst | input | 1 | Synchronous active-high reset |
| bi_addr | input | 16 | Incoming bus address |
| bi_data | input | 16 | Incoming bus data |
| bi_rw | input | 1 | Incoming direction, 1 = write |
| bi_valid | input | 1 | Incoming transaction valid |
| bo_addr | output | 16 | Forwarded bus address |
| bo_data | output | 16 | Forwarded data or read result |
| bo_rw | output | 1 | Forwarded direction |
| bo_valid | output | 1 | Forwarded valid |
| usr_addr | input | clog2(DEPTH) | User word address |
| usr_wdata | input | WIDTH | User write word |
| usr_we | input | 1 | User write enable |
| usr_rdata | output | WIDTH | User read word, registered |

## Verification
A wrong decode of bank or word index shows up as a read returning the wrong slice value. That error appears on `bo_data` in the cycle right after the read is issued, and later as a corrupted word on `usr_rdata` one cycle after a user read. A state machine stuck in the wrong state shows up in the next cycle in three ways. Pass-through data gets replaced, a write's data is overwritten by a read value, or `bo_valid` does not follow `bi_valid`. Masking or collision faults stay hidden in storage until the word is read back, and they appear one cycle after that read.

// File: rtl/smem_pkg.sv
package smem_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PASS,
        ST_READ,
        ST_WRITE
    } bus_state_e;

    function automatic int slice_count(input int width);
        return (width + 15) / 16;
    endfunction

    function automatic int slice_bits(input int width, input int k);
        int rem;
        rem = width - 16 * k;
        return (rem >= 16) ? 16 : rem;
    endfunction

endpackage

// File: rtl/smem_decode.sv
module smem_decode #(
    parameter logic [15:0] BASE_ADDR = 16'h0100,
    parameter int          DEPTH     = 16,
    parameter int          NSLICE    = 3,
    parameter int          AW        = 4,
    parameter int          SLW       = 2
) (
    input  logic [15:0]    addr,
    input  logic           valid,
    output logic           hit,
    output logic [SLW-1:0] slice_idx,
    output logic [AW-1:0]  word_idx
);
    localparam int SPAN = NSLICE * DEPTH;

    logic [31:0] offset;

    always_comb begin
        offset    = 32'(addr) - 32'(BASE_ADDR);
        hit       = valid && (addr >= BASE_ADDR) && (offset < 32'(SPAN));
        slice_idx = SLW'(offset / 32'(DEPTH));
        word_idx  = AW'(offset % 32'(DEPTH));
    end
endmodule

// File: rtl/smem_slice.sv
module smem_slice #(
    parameter int SW    = 16,
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [15:0]   bus_wdata,
    output logic [15:0]   bus_rdata,
    input  logic          usr_we,
    input  logic [AW-1:0] usr_addr,
    input  logic [SW-1:0] usr_wdata,
    output logic [SW-1:0] usr_rdata
);
    logic [SW-1:0] store [DEPTH];
    logic          bus_blocked;

    assign bus_blocked = usr_we && (usr_addr == bus_addr);

    always_ff @(posedge clk) begin
        if (bus_we && !bus_blocked)
            store[bus_addr] <= bus_wdata[SW-1:0];
        if (usr_we)
            store[usr_addr] <= usr_wdata;
    end

    // unused upper bits are not stored and come back as zero
    assign bus_rdata = 16'(store[bus_addr]);
    assign usr_rdata = store[usr_addr];
endmodule

// File: rtl/sliced_bus_mem.sv
module sliced_bus_mem
    import smem_pkg::*;
#(
    parameter int          WIDTH     = 34,
    parameter int          DEPTH     = 16,
    parameter logic [15:0] BASE_ADDR = 16'h0100,
    localparam int         AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [15:0]      bi_addr,
    input  logic [15:0]      bi_data,
    input  logic             bi_rw,
    input  logic             bi_valid,
    output logic [15:0]      bo_addr,
    output logic [15:0]      bo_data,
    output logic             bo_rw,
    output logic             bo_valid,
    input  logic [AW-1:0]    usr_addr,
    input  logic [WIDTH-1:0] usr_wdata,
    input  logic             usr_we,
    output logic [WIDTH-1:0] usr_rdata
);
    localparam int NSLICE = slice_count(WIDTH);
    localparam int SLW    = (NSLICE > 1) ? $clog2(NSLICE) : 1;

    bus_state_e        state_q, state_d;
    logic              hit;
    logic [SLW-1:0]    slice_idx;
    logic [AW-1:0]     word_idx;
    logic [15:0]       slice_rd [NSLICE];
    logic [WIDTH-1:0]  usr_word;

    smem_decode #(
        .BASE_ADDR(BASE_ADDR), .DEPTH(DEPTH), .NSLICE(NSLICE), .AW(AW), .SLW(SLW)
    ) u_dec (
        .addr(bi_addr), .valid(bi_valid),
        .hit(hit), .slice_idx(slice_idx), .word_idx(word_idx)
    );

    for (genvar k = 0; k < NSLICE; k++) begin : g_slice
        localparam int SW = slice_bits(WIDTH, k);
        logic          we_k;
        logic [SW-1:0] usr_rd_k;

        assign we_k = hit && bi_rw && (slice_idx == SLW'(k));

        smem_slice #(.SW(SW), .DEPTH(DEPTH), .AW(AW)) u_slice (
            .clk(clk),
            .bus_we(we_k), .bus_addr(word_idx), .bus_wdata(bi_data),
            .bus_rdata(slice_rd[k]),
            .usr_we(usr_we), .usr_addr(usr_addr),
            .usr_wdata(usr_wdata[16*k +: SW]), .usr_rdata(usr_rd_k)
        );

        assign usr_word[16*k +: SW] = usr_rd_k;
    end

    // next state: the kind of transaction the output stage will carry
    always_comb begin
        if (!bi_valid)  state_d = ST_IDLE;
        else if (!hit)  state_d = ST_PASS;
        else if (bi_rw) state_d = ST_WRITE;
        else            state_d = ST_READ;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            bo_addr   <= '0;
            bo_data   <= '0;
            bo_rw     <= 1'b0;
            usr_rdata <= '0;
        end else begin
            bo_addr   <= bi_addr;
            bo_rw     <= bi_rw;
            usr_rdata <= usr_word;
            unique case (state_d)
                ST_READ:  bo_data <= slice_rd[slice_idx];
                ST_IDLE,
                ST_PASS,
                ST_WRITE: bo_data <= bi_data;
            endcase
        end
    end

    assign bo_valid = (state_q != ST_IDLE);
endmodule

// File: rtl/sliced_bus_mem_chk.sv
module sliced_bus_mem_chk #(
    parameter int          WIDTH     = 34,
    parameter int          DEPTH     = 16,
    parameter logic [15:0] BASE_ADDR = 16'h0100
) (
    input logic        clk,
    input logic        rst,
    input logic [15:0] bi_addr,
    input logic [15:0] bi_data,
    input logic        bi_rw,
    input logic        bi_valid,
    input logic [15:0] bo_addr,
    input logic [15:0] bo_data,
    input logic        bo_rw,
    input logic        bo_valid
);
    localparam int          NS     = (WIDTH + 15) / 16;
    localparam int          TOPW   = WIDTH - 16 * (NS - 1);
    localparam logic [15:0] TOPMSK = 16'((32'd1 << TOPW) - 32'd1);
    localparam logic [31:0] LO     = 32'(BASE_ADDR);
    localparam logic [31:0] HI     = 32'(BASE_ADDR) + 32'(NS * DEPTH);
    localparam logic [31:0] TOPLO  = 32'(BASE_ADDR) + 32'((NS - 1) * DEPTH);

    logic in_rng, in_top;
    assign in_rng = (32'(bi_addr) >= LO) && (32'(bi_addr) < HI);
    assign in_top = (32'(bi_addr) >= TOPLO) && (32'(bi_addr) < HI);

    assert_valid_latency_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (bo_valid == $past(bi_valid)));

    assert_fwd_fields_R2: assert property (@(posedge clk) disable iff (rst)
        bi_valid |=> (bo_addr == $past(bi_addr)) && (bo_rw == $past(bi_rw)));

    assert_pass_data_R5: assert property (@(posedge clk) disable iff (rst)
        (bi_valid && !in_rng) |=> (bo_data == $past(bi_data)));

    assert_write_data_R3: assert property (@(posedge clk) disable iff (rst)
        (bi_valid && bi_rw) |=> (bo_data == $past(bi_data)));

    assert_top_mask_R4: assert property (@(posedge clk) disable iff (rst)
        (bi_valid && !bi_rw && in_top) |=> ((bo_data & ~TOPMSK) == 16'h0000));
endmodule

bind sliced_bus_mem sliced_bus_mem_chk #(
    .WIDTH(WIDTH), .DEPTH(DEPTH), .BASE_ADDR(BASE_ADDR)
) u_chk (
    .clk(clk), .rst(rst),
    .bi_addr(bi_addr), .bi_data(bi_data), .bi_rw(bi_rw), .bi_valid(bi_valid),
    .bo_addr(bo_addr), .bo_data(bo_data), .bo_rw(bo_rw), .bo_valid(bo_valid)
);

// File: tb/sim_sliced_bus_mem.sv
module sim_sliced_bus_mem;
    localparam int          W    = 34;
    localparam int          D    = 16;
    localparam logic [15:0] BASE = 16'h0100;
    localparam int          NS   = (W + 15) / 16;
    localparam int          AW   = $clog2(D);

    logic          clk = 0;
    logic          rst = 1;
    logic [15:0]   bi_addr = 0, bi_data = 0;
    logic          bi_rw = 0, bi_valid = 0;
    logic [15:0]   bo_addr, bo_data;
    logic          bo_rw, bo_valid;
    logic [AW-1:0] usr_addr = 0;
    logic [W-1:0]  usr_wdata = 0;
    logic          usr_we = 0;
    logic [W-1:0]  usr_rdata;

    int n_chk = 0, n_bad = 0;
    logic [W-1:0] mdl [D];

    always #2 clk = ~clk;

    sliced_bus_mem #(.WIDTH(W), .DEPTH(D), .BASE_ADDR(BASE)) u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mdl_rd(input int k, input int a);
        logic [63:0] t;
        t = 64'(mdl[a]);
        return t[k*16 +: 16];
    endfunction

    function automatic void mdl_wr(input int k, input int a, input logic [15:0] d);
        logic [63:0] t;
        t = 64'(mdl[a]);
        t[k*16 +: 16] = d;
        mdl[a] = t[W-1:0];
    endfunction

    function automatic logic [15:0] baddr(input int k, input int a);
        return BASE + 16'(k * D + a);
    endfunction

    task automatic bus(input logic [15:0] a, input logic [15:0] d, input logic rw, output logic [15:0] q);
        @(negedge clk);
        bi_addr = a; bi_data = d; bi_rw = rw; bi_valid = 1;
        @(negedge clk);
        bi_valid = 0;
        q = bo_data;
        chk(bo_valid == 1 && bo_addr == a && bo_rw == rw, "R6/R2 forward", {bo_valid, bo_rw, bo_addr}, {2'b11 & {1'b1, rw}, a});
    endtask

    task automatic uwr(input int a, input logic [W-1:0] w);
        @(negedge clk);
        usr_addr = AW'(a); usr_wdata = w; usr_we = 1;
        @(negedge clk);
        usr_we = 0;
        mdl[a] = w;
    endtask

    task automatic urd(input int a, output logic [W-1:0] w);
        @(negedge clk);
        usr_addr = AW'(a); usr_we = 0;
        @(negedge clk);
        w = usr_rdata;
    endtask

    task automatic verify_all(input string req);
        logic [W-1:0] w;
        for (int a = 0; a < D; a++) begin
            urd(a, w);
            chk(w == mdl[a], req, 64'(w), 64'(mdl[a]));
        end
    endtask

    initial begin
        logic [15:0] q;
        logic [W-1:0] w;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(bo_valid == 0 && bo_addr == 0 && bo_data == 0 && bo_rw == 0, "R9 reset",
            {bo_valid, bo_rw, bo_addr, bo_data}, 0);
        rst = 0;

        // R7: fill through the user port and read back
        for (int a = 0; a < D; a++) uwr(a, W'({$urandom, $urandom}));
        verify_all("R7 user word");

        // R1 R2: random in-range bus reads
        for (int i = 0; i < 40; i++) begin
            int k = int'($urandom % NS);
            int a = int'($urandom % D);
            bus(baddr(k, a), 16'($urandom), 1'b0, q);
            chk(q == mdl_rd(k, a), "R1 R2 read slice", 64'(q), 64'(mdl_rd(k, a)));
        end

        // R1 R3 R4: random in-range bus writes, data forwarded unchanged
        for (int i = 0; i < 40; i++) begin
            int k = int'($urandom % NS);
            int a = int'($urandom % D);
            logic [15:0] d = 16'($urandom);
            bus(baddr(k, a), d, 1'b1, q);
            chk(q == d, "R3 write data forward", 64'(q), 64'(d));
            mdl_wr(k, a, d);
        end
        verify_all("R1 R3 bus write");

        // R6: valid drops one cycle after input drops
        @(negedge clk);
        chk(bo_valid == 0, "R6 idle after", 64'(bo_valid), 0);

        // R4: top slice masking at both boundaries of the word range
        bus(baddr(NS - 1, 0), 16'hFFFF, 1'b1, q);  mdl_wr(NS - 1, 0, 16'hFFFF);
        bus(baddr(NS - 1, D - 1), 16'hFFFF, 1'b1, q); mdl_wr(NS - 1, D - 1, 16'hFFFF);
        bus(baddr(NS - 1, D - 1), 16'h1234, 1'b0, q);
        chk(q == 16'h0003, "R4 masked read", 64'(q), 64'h3);
        urd(0, w);
        chk(w == mdl[0], "R4 masked store", 64'(w), 64'(mdl[0]));

        // R1 boundary: first address of window
        bus(BASE, 16'hA5A5, 1'b1, q); mdl_wr(0, 0, 16'hA5A5);
        bus(BASE, 16'h0000, 1'b0, q);
        chk(q == 16'hA5A5, "R1 base address", 64'(q), 64'hA5A5);

        // R5: out-of-range below and just above the window
        bus(BASE - 16'd1, 16'h1111, 1'b0, q);
        chk(q == 16'h1111, "R5 below read pass", 64'(q), 64'h1111);
        bus(BASE + 16'(NS * D), 16'h2222, 1'b0, q);
        chk(q == 16'h2222, "R5 above read pass", 64'(q), 64'h2222);
        bus(BASE + 16'(NS * D), 16'h3333, 1'b1, q);
        bus(BASE - 16'd1, 16'h4444, 1'b1, q);
        bus(16'hFFFF, 16'h5555, 1'b1, q);
        chk(q == 16'h5555, "R5 write pass", 64'(q), 64'h5555);
        verify_all("R5 no change");

        // R8: same-word collision, user wins
        @(negedge clk);
        bi_addr = baddr(1, 5); bi_data = 16'hDEAD; bi_rw = 1; bi_valid = 1;
        usr_addr = AW'(5); usr_wdata = W'(64'h2_1234_5678); usr_we = 1;
        @(negedge clk);
        bi_valid = 0; usr_we = 0;
        mdl[5] = W'(64'h2_1234_5678);
        // different words same cycle: both land
        @(negedge clk);
        bi_addr = baddr(0, 7); bi_data = 16'hBEEF; bi_rw = 1; bi_valid = 1;
        usr_addr = AW'(8); usr_wdata = W'(64'h1_0000_FFFF); usr_we = 1;
        @(negedge clk);
        bi_valid = 0; usr_we = 0;
        mdl[8] = W'(64'h1_0000_FFFF); mdl_wr(0, 7, 16'hBEEF);
        urd(5, w);
        chk(w == mdl[5], "R8 collision user wins", 64'(w), 64'(mdl[5]));
        verify_all("R8 R7 parallel");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule